// File: doc/BRIEF.md
# Bidirectional Line Sampling Controller

This block sequences the capture of one display line of grayscale codes into an 80-slot sampling register. Each slot holds three 6-bit codes, one per colour lane, so a line is 240 codes. Each capture writes all three lanes of one slot in the same clock edge. The block drives a write strobe, a slot index and the three codes. The register storage itself sits outside the block.

A static direction input sets the fill order. When it is high, slots fill upward from the first. When it is low, they fill downward from the last. The same input decides which of two enable pins listens for the start of a line and which one passes a start pulse on to the next device in a chain.

That pass-on pulse is issued one clock early. A downstream device that samples it begins capturing on the clock right after the final local capture, so a chain of devices fills one long line with no gap between them.

Top module: `line_sampler_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the block idle. After reset, `wr_valid` is 0 and both `pin_a_out` and `pin_b_out` are 0.
- R2: When the block is idle, a high level on the active enable input at a rising edge arms it. `wr_valid` is then high during the next cycle, so the first capture happens on the following rising edge.
- R3: A line is exactly `SLOTS` (80) consecutive captures, one per cycle with `wr_valid` high. After the last capture, `wr_valid` is low.
- R4: With `dir_up` = 1, `wr_idx` steps through 0, 1, …, 79 (slot 1 is index 0).
- R5: With `dir_up` = 0, `wr_idx` steps through 79, 78, …, 0.
- R6: With `dir_up` = 1, pin A is the enable input: `pin_a_oe` = 0, `pin_b_oe` = 1, and `pin_a_out` stays 0. With `dir_up` = 0 the roles swap. A high level on the pin that is currently the output side never arms the block.
- R7: The cascade output (`pin_b_out` when `dir_up` = 1, `pin_a_out` when `dir_up` = 0) rises on the edge one clock before the final capture. It is high for exactly one cycle, the cycle whose capture is the final one. The other output stays 0.
- R8: A high level on the enable input while a transfer is active has no effect. This includes the edge of the final capture. The line still has exactly 80 captures, and the block is idle afterwards.
- R9: `wr_codes` carries the three lanes unchanged. Lane L occupies bits [6L+5:6L]. Each code is plain binary with bit 5 as the MSB, weighting the bits 32, 16, 8, 4, 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | Fill direction: 1 = upward, pin A is the input; 0 = downward, pin B is the input |
| pin_a_in | input | 1 | Level seen on enable pin A |
| pin_b_in | input | 1 | Level seen on enable pin B |
| pin_a_out | output | 1 | Value driven onto pin A |
| pin_b_out | output | 1 | Value driven onto pin B |
| pin_a_oe | output | 1 | Output-driver enable for pin A |
| pin_b_oe | output | 1 | Output-driver enable for pin B |
| code_in | input | 18 | Three 6-bit grayscale codes, lane 0 in the low bits |
| wr_valid | output | 1 | Capture strobe: the slot is written at the end of this cycle |
| wr_idx | output | 7 | Zero-based slot index being written |
| wr_codes | output | 18 | Codes to write into the slot |

## Verification
The final capture and the cascade pulse always share one cycle. The enable input can also go high on that same edge, and that request must be dropped. The bench holds the enable input high through the final capture cycle. It then checks that the cascade output is high only in that cycle and that the slot index is the end slot for the selected direction. It also checks that the block is idle on the next cycle rather than starting a second line. A second collision comes from raising the enable input in the middle of a line; the pass count and the index sequence must stay intact.

// File: rtl/line_sampler_ctrl.sv
module line_sampler_ctrl #(
  parameter int SLOTS  = 80,
  parameter int CODE_W = 6,
  parameter int LANES  = 3,
  localparam int PW = $clog2(SLOTS),
  localparam int DW = LANES * CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_up,
  input  logic          pin_a_in,
  input  logic          pin_b_in,
  output logic          pin_a_out,
  output logic          pin_b_out,
  output logic          pin_a_oe,
  output logic          pin_b_oe,
  input  logic [DW-1:0] code_in,
  output logic          wr_valid,
  output logic [PW-1:0] wr_idx,
  output logic [DW-1:0] wr_codes
);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);
  localparam logic [PW-1:0] PRE  = PW'(SLOTS - 2);

  logic          busy;
  logic [PW-1:0] cnt;
  logic          casc;
  logic          start;

  assign start = dir_up ? pin_a_in : pin_b_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      casc <= 1'b0;
    end else begin
      casc <= busy && (cnt == PRE);
      if (!busy) begin
        cnt <= '0;
        if (start) busy <= 1'b1;
      end else if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + PW'(1);
      end
    end
  end

  assign wr_valid  = busy;
  assign wr_idx    = dir_up ? cnt : LAST - cnt;
  assign wr_codes  = code_in;
  assign pin_a_oe  = ~dir_up;
  assign pin_b_oe  = dir_up;
  assign pin_a_out = ~dir_up & casc;
  assign pin_b_out = dir_up & casc;
endmodule

// File: rtl/line_sampler_chk.sv
module line_sampler_chk #(
  parameter int SLOTS  = 80,
  parameter int CODE_W = 6,
  parameter int LANES  = 3,
  localparam int PW = $clog2(SLOTS),
  localparam int DW = LANES * CODE_W
) (
  input logic          clk,
  input logic          rst,
  input logic          dir_up,
  input logic          pin_a_in,
  input logic          pin_b_in,
  input logic          pin_a_out,
  input logic          pin_b_out,
  input logic          pin_a_oe,
  input logic          pin_b_oe,
  input logic [DW-1:0] code_in,
  input logic          wr_valid,
  input logic [PW-1:0] wr_idx,
  input logic [DW-1:0] wr_codes
);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);
  logic act_in, casc_any, end_slot;
  assign act_in   = dir_up ? pin_a_in : pin_b_in;
  assign casc_any = pin_a_out | pin_b_out;
  assign end_slot = dir_up ? (wr_idx == LAST) : (wr_idx == '0);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !wr_valid && !pin_a_out && !pin_b_out);
  // R2
  arm_next_chk: assert property (@(posedge clk) disable iff (rst) (!wr_valid && act_in) |=> wr_valid);
  // R3
  line_end_chk: assert property (@(posedge clk) disable iff (rst) (wr_valid && end_slot) |=> !wr_valid);
  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && $past(wr_valid) && dir_up && $past(dir_up)) |-> wr_idx == $past(wr_idx) + PW'(1));
  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && $past(wr_valid) && !dir_up && !$past(dir_up)) |-> wr_idx == $past(wr_idx) - PW'(1));
  // R6
  pin_role_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_b_oe == dir_up) && (pin_a_oe != pin_b_oe) && !(pin_a_out && !pin_a_oe) && !(pin_b_out && !pin_b_oe));
  // R7
  casc_last_chk: assert property (@(posedge clk) disable iff (rst) casc_any |-> wr_valid && end_slot);
  // R7
  casc_single_chk: assert property (@(posedge clk) disable iff (rst) casc_any |=> !casc_any);
  // R9
  code_pass_chk: assert property (@(posedge clk) disable iff (rst) wr_valid |-> wr_codes == code_in);
endmodule

bind line_sampler_ctrl line_sampler_chk #(.SLOTS(SLOTS), .CODE_W(CODE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .dir_up(dir_up), .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
  .pin_a_out(pin_a_out), .pin_b_out(pin_b_out), .pin_a_oe(pin_a_oe), .pin_b_oe(pin_b_oe),
  .code_in(code_in), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_codes(wr_codes));

// File: tb/line_sampler_ctrl_bench.sv
module line_sampler_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 80;
  localparam int PW = $clog2(SLOTS);

  logic clk = 0, rst = 1, dir_up = 1, pin_a_in = 0, pin_b_in = 0;
  logic pin_a_out, pin_b_out, pin_a_oe, pin_b_oe, wr_valid;
  logic [17:0] code_in = '0, wr_codes;
  logic [PW-1:0] wr_idx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_sampler_ctrl u_line_sampler_ctrl (
    .clk(clk), .rst(rst), .dir_up(dir_up), .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
    .pin_a_out(pin_a_out), .pin_b_out(pin_b_out), .pin_a_oe(pin_a_oe), .pin_b_oe(pin_b_oe),
    .code_in(code_in), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_codes(wr_codes));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_en(input bit d, input bit v);
    if (d) pin_a_in = v; else pin_b_in = v;
  endtask

  task automatic run_line(input bit d, input bit hold_last, input int salt);
    int lane_v [3];
    @(negedge clk);
    dir_up = d;
    #1;
    chk(pin_b_oe == d && pin_a_oe == !d, "R6 oe", {pin_a_oe, pin_b_oe}, {!d, d});
    chk(!wr_valid, "R2 idle before arm", wr_valid, 0);
    set_en(d, 1);
    @(negedge clk);
    set_en(d, 0);
    for (int k = 0; k < SLOTS; k++) begin
      for (int l = 0; l < 3; l++) lane_v[l] = (k * 7 + l * 13 + salt) % 64;
      code_in = {6'(lane_v[2]), 6'(lane_v[1]), 6'(lane_v[0])};
      if (k == 40) set_en(d, 1);
      if (k == 41) set_en(d, 0);
      if (k == SLOTS - 1 && hold_last) set_en(d, 1);
      #1;
      chk(wr_valid, k == 0 ? "R2 first capture" : "R3 capture", wr_valid, 1);
      if (d) chk(int'(wr_idx) == k, "R4 index", wr_idx, k);
      else   chk(int'(wr_idx) == SLOTS - 1 - k, "R5 index", wr_idx, SLOTS - 1 - k);
      for (int l = 0; l < 3; l++) begin
        int w = 0;
        for (int b = 0; b < 6; b++) w += int'(wr_codes[6*l+b]) * (1 << b);
        chk(w == lane_v[l], "R9 lane code", w, lane_v[l]);
      end
      chk((d ? pin_b_out : pin_a_out) == (k == SLOTS - 1), "R7 cascade out",
          d ? pin_b_out : pin_a_out, k == SLOTS - 1);
      chk((d ? pin_a_out : pin_b_out) == 0, "R6 input pin not driven",
          d ? pin_a_out : pin_b_out, 0);
      @(negedge clk);
    end
    #1;
    chk(!wr_valid, hold_last ? "R8 ignored at last edge" : "R3 line end", wr_valid, 0);
    chk(!pin_a_out && !pin_b_out, "R7 cascade one cycle", {pin_a_out, pin_b_out}, 0);
    set_en(d, 0);
    @(negedge clk);
    #1;
    chk(!wr_valid, "R8 stays idle", wr_valid, 0);
  endtask

  task automatic wrong_pin(input bit d);
    @(negedge clk);
    dir_up = d;
    set_en(!d, 1);
    @(negedge clk);
    set_en(!d, 0);
    #1;
    chk(!wr_valid, "R6 output-side pin ignored", wr_valid, 0);
    @(negedge clk);
    #1;
    chk(!wr_valid, "R6 output-side pin ignored later", wr_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!wr_valid, "R1 reset valid", wr_valid, 0);
    chk(!pin_a_out && !pin_b_out, "R1 reset outs", {pin_a_out, pin_b_out}, 0);
    rst = 0;
    run_line(1, 0, 3);
    run_line(0, 0, 11);
    run_line(1, 1, 29);
    run_line(0, 1, 41);
    wrong_pin(1);
    wrong_pin(0);
    @(negedge clk);
    dir_up = 1;
    pin_a_in = 1;
    @(negedge clk);
    pin_a_in = 0;
    rst = 1;
    @(negedge clk);
    #1;
    chk(!wr_valid && !pin_b_out, "R1 reset mid-line", wr_valid, 0);
    rst = 0;
    run_line(1, 0, 5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule